// File: doc/BRIEF.md
# Register Write-Lock Controller

This block guards a small group of registers in a peripheral bus slave. It owns one 32-bit lock register. Four of its bits are lock flags, and each flag protects one target: the lock register itself, a status register, a control register and a time-compensation register. A flag of 1 lets bus writes to its target through. A flag of 0 drops those writes without a bus error. Software can clear a flag by writing 0 to it. Software can never set a flag again. Only a reset restores it.

The block decodes each bus write and turns it into a write-enable qualifier for the addressed target. A qualifier is high only when the target's flag is 1. The protected registers sit outside the block and consume these qualifiers. There are two reset sources. The asynchronous power-on reset restores every flag. The synchronous software reset restores all flags except the control-register flag, so a control lock survives it. Reads of the lock register return its full 32-bit image.

Top module: `wr_lock_guard`

## Requirements
- R1: After power-on reset the lock register reads 0x0000_00FF, so every flag is 1 (unlocked).
- R2: Bits 31..8 always read 0. Bits 7 and 2..0 always read 1. Writes never change any of these bits.
- R3: A write to the lock register (address 0x18) that is let through sets each flag to its old value ANDed with the written bit. The flags sit at bit 6 (lock register), bit 5 (status), bit 4 (control) and bit 3 (time compensation). Writing 1 to a cleared flag leaves it at 0.
- R4: While the software reset is high, the clock edge sets bits 6, 5 and 3 to 1 and discards any lock-register write made in that cycle.
- R5: The control flag (bit 4) is restored only by power-on reset. The software reset leaves it unchanged.
- R6: When bit 6 is 0, every write to the lock register is dropped, including writes that would clear other flags.
- R7: The write-enable outputs are weLock, weStatus (address 0x14), weCtrl (address 0x10) and weComp (address 0x0C). Each one is high in a cycle only when there is a bus write to its address and its flag is 1. Otherwise it stays low and no error is raised.
- R8: Flags changed by a lock-register write affect the write enables from the next cycle on. A write in the same cycle is qualified by the old flag values.
- R9: Power-on reset takes priority when it is asserted together with the software reset. The register returns to 0x0000_00FF.
- R10: rdData carries the lock register image when busRdEn is high and the address is 0x18. In every other case it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Asynchronous power-on reset, active low |
| swRst | input | 1 | Synchronous software reset, active high |
| busWrEn | input | 1 | Bus write strobe |
| busRdEn | input | 1 | Bus read strobe |
| busAddr | input | 8 | Bus register address |
| busWrData | input | 32 | Bus write data |
| rdData | output | 32 | Lock register read data |
| weLock | output | 1 | Write qualifier for the lock register |
| weStatus | output | 1 | Write qualifier for the status register |
| weCtrl | output | 1 | Write qualifier for the control register |
| weComp | output | 1 | Write qualifier for the time-compensation register |

## Verification
The assertions assume that the four target addresses are distinct. They also assume that every change to a flag comes from a qualified lock write, from the software reset, or from power-on reset. The one-hot check on the qualifiers relies on the bus presenting one address per cycle. The bench changes inputs only at the falling clock edge, so each strobe is held for one full clock. It releases power-on reset at a falling edge, which keeps reset removal clear of the sampling edge.

// File: rtl/wr_lock_pkg.sv
package wr_lock_pkg;
  localparam int NLOCK = 4;     // flags at bits 3..6
  localparam int LOCK_LSB = 3;
  localparam int CTRL_IDX = 1;  // index of the flag kept through software reset

  typedef struct packed {
    logic lockOk;
    logic statusOk;
    logic ctrlOk;
    logic compOk;
  } lockView_t;

  typedef struct packed {
    logic wrLock;
    logic rdLock;
    logic swRestore;
  } dpStrobe_t;
endpackage

// File: rtl/wr_lock_ctrl.sv
module wr_lock_ctrl
  import wr_lock_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 8'h18,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'h14,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h10,
  parameter logic [ADDR_W-1:0] COMP_ADDR = 8'h0C
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              swRst,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  lockView_t         lockView,
  output dpStrobe_t         strobe,
  output logic              weLock,
  output logic              weStatus,
  output logic              weCtrl,
  output logic              weComp
);
  logic hitLock, hitStatus, hitCtrl, hitComp;

  always_comb begin
    hitLock   = (busAddr == LOCK_ADDR);
    hitStatus = (busAddr == STATUS_ADDR);
    hitCtrl   = (busAddr == CTRL_ADDR);
    hitComp   = (busAddr == COMP_ADDR);
    weLock    = busWrEn && hitLock && lockView.lockOk;
    weStatus  = busWrEn && hitStatus && lockView.statusOk;
    weCtrl    = busWrEn && hitCtrl && lockView.ctrlOk;
    weComp    = busWrEn && hitComp && lockView.compOk;
    strobe.wrLock    = weLock;
    strobe.rdLock    = busRdEn && hitLock;
    strobe.swRestore = swRst;
  end

  assert_we_onehot_R7: assert property (@(posedge clk) disable iff (!porRstN)
    $onehot0({weLock, weStatus, weCtrl, weComp}));
  assert_we_needs_write_R7: assert property (@(posedge clk) disable iff (!porRstN)
    (weLock || weStatus || weCtrl || weComp) |-> busWrEn);
endmodule

// File: rtl/wr_lock_dp.sv
module wr_lock_dp
  import wr_lock_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              porRstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] wrData,
  output lockView_t         lockView,
  output logic [DATA_W-1:0] rdData
);
  localparam int PAD_W = DATA_W - 8;

  logic [NLOCK-1:0] lockQ;
  logic [DATA_W-1:0] image;

  for (genvar gi = 0; gi < NLOCK; gi++) begin : g_flag
    localparam bit SW_RESTORABLE = (gi != CTRL_IDX);
    always_ff @(posedge clk or negedge porRstN) begin
      if (!porRstN)
        lockQ[gi] <= 1'b1;
      else if (strobe.swRestore) begin
        if (SW_RESTORABLE) lockQ[gi] <= 1'b1;
      end else if (strobe.wrLock)
        lockQ[gi] <= lockQ[gi] & wrData[LOCK_LSB + gi];
    end
  end

  always_comb begin
    lockView.compOk   = lockQ[0];
    lockView.ctrlOk   = lockQ[1];
    lockView.statusOk = lockQ[2];
    lockView.lockOk   = lockQ[3];
    image  = {{PAD_W{1'b0}}, 1'b1, lockQ, 3'b111};
    rdData = strobe.rdLock ? image : '0;
  end

  assert_idle_stable_R3: assert property (@(posedge clk) disable iff (!porRstN)
    (!strobe.swRestore && !strobe.wrLock) |=> $stable(lockQ));
  assert_no_rise_R3: assert property (@(posedge clk) disable iff (!porRstN)
    !strobe.swRestore |=> ((lockQ & ~$past(lockQ)) == '0));
  assert_sw_restore_R4: assert property (@(posedge clk) disable iff (!porRstN)
    strobe.swRestore |=> (lockQ[0] && lockQ[2] && lockQ[3]));
  assert_ctrl_kept_R5: assert property (@(posedge clk) disable iff (!porRstN)
    !lockQ[CTRL_IDX] |=> !lockQ[CTRL_IDX]);
  assert_self_lock_R6: assert property (@(posedge clk) disable iff (!porRstN)
    (!lockQ[3] && !strobe.swRestore) |=> $stable(lockQ));
endmodule

// File: rtl/wr_lock_guard.sv
module wr_lock_guard
  import wr_lock_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 8'h18,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'h14,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h10,
  parameter logic [ADDR_W-1:0] COMP_ADDR = 8'h0C
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              swRst,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] rdData,
  output logic              weLock,
  output logic              weStatus,
  output logic              weCtrl,
  output logic              weComp
);
  dpStrobe_t strobe;
  lockView_t lockView;

  wr_lock_ctrl #(
    .ADDR_W(ADDR_W), .LOCK_ADDR(LOCK_ADDR), .STATUS_ADDR(STATUS_ADDR),
    .CTRL_ADDR(CTRL_ADDR), .COMP_ADDR(COMP_ADDR)
  ) u_ctrl (
    .clk(clk), .porRstN(porRstN), .swRst(swRst), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busAddr(busAddr), .lockView(lockView),
    .strobe(strobe), .weLock(weLock), .weStatus(weStatus),
    .weCtrl(weCtrl), .weComp(weComp)
  );

  wr_lock_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .porRstN(porRstN), .strobe(strobe), .wrData(busWrData),
    .lockView(lockView), .rdData(rdData)
  );
endmodule

// File: tb/sim_wr_lock_guard.sv
module sim_wr_lock_guard;
  logic clk = 1'b0;
  logic porRstN = 1'b0;
  logic swRst = 1'b0;
  logic busWrEn = 1'b0, busRdEn = 1'b0;
  logic [7:0] busAddr = 8'h0;
  logic [31:0] busWrData = 32'h0;
  logic [31:0] rdData;
  logic weLock, weStatus, weCtrl, weComp;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [3:0] mLock = 4'hF;              // index 3=lock,2=status,1=ctrl,0=comp
  logic [31:0] dStatus = 0, dCtrl = 0, dComp = 0;
  logic [31:0] mStatus = 0, mCtrl = 0, mComp = 0;

  always #2 clk = ~clk;                   // 250 MHz

  wr_lock_guard u0 (
    .clk(clk), .porRstN(porRstN), .swRst(swRst), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busAddr(busAddr), .busWrData(busWrData),
    .rdData(rdData), .weLock(weLock), .weStatus(weStatus),
    .weCtrl(weCtrl), .weComp(weComp)
  );

  // protected registers as simple storage
  always_ff @(posedge clk) begin
    if (weStatus) dStatus <= busWrData;
    if (weCtrl)   dCtrl   <= busWrData;
    if (weComp)   dComp   <= busWrData;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] image();
    return {24'h0, 1'b1, mLock, 3'b111};
  endfunction

  task automatic step(input logic w, input logic r, input logic [7:0] a,
                      input logic [31:0] d, input logic s, input string tag);
    logic [3:0] expWe;
    @(negedge clk);
    busWrEn = w; busRdEn = r; busAddr = a; busWrData = d; swRst = s;
    #1;
    expWe = {w && a == 8'h18 && mLock[3], w && a == 8'h14 && mLock[2],
             w && a == 8'h10 && mLock[1], w && a == 8'h0C && mLock[0]};
    check({tag, " we"}, {28'h0, weLock, weStatus, weCtrl, weComp}, {28'h0, expWe});
    check({tag, " rd"}, rdData, (r && a == 8'h18) ? image() : 32'h0);
    @(posedge clk);
    if (s) mLock = {1'b1, 1'b1, mLock[1], 1'b1};
    else if (expWe[3]) mLock = mLock & d[6:3];
    if (expWe[2]) mStatus = d;
    if (expWe[1]) mCtrl = d;
    if (expWe[0]) mComp = d;
  endtask

  task automatic idle();
    @(negedge clk);
    busWrEn = 0; busRdEn = 0; swRst = 0;
  endtask

  initial begin
    #100000;
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    porRstN = 1;
    step(0, 1, 8'h18, 0, 0, "R1 reset image");
    step(1, 0, 8'h14, 32'h11, 0, "R7 status open");
    step(1, 0, 8'h10, 32'h22, 0, "R7 ctrl open");
    step(1, 0, 8'h0C, 32'h33, 0, "R7 comp open");
    step(1, 1, 8'h18, 32'hFFFF_FFEF, 0, "R3 clear ctrl");
    step(0, 1, 8'h18, 0, 0, "R2 reserved after clear");
    step(1, 1, 8'h18, 32'hFFFF_FFFF, 0, "R3 write one no set");
    step(0, 1, 8'h18, 0, 0, "R3 still cleared");
    step(1, 0, 8'h10, 32'h44, 0, "R7 ctrl dropped");
    step(1, 0, 8'h18, 32'hFFFF_FFF7, 0, "R3 clear comp");
    step(1, 0, 8'h0C, 32'h55, 0, "R7 comp dropped");
    step(0, 0, 8'h18, 0, 1, "R4 sw reset");
    step(0, 1, 8'h18, 0, 0, "R5 ctrl survives sw reset");
    step(1, 0, 8'h0C, 32'h66, 0, "R4 comp reopened");
    step(1, 0, 8'h18, 32'h0000_00BF, 0, "R8 self lock same cycle");
    step(1, 1, 8'h18, 32'h0, 0, "R6 lock write dropped");
    step(0, 1, 8'h18, 0, 0, "R6 image unchanged");
    step(1, 0, 8'h14, 32'h77, 0, "R6 status still open");
    step(1, 1, 8'h18, 32'h0, 1, "R4 sw reset beats write");
    step(0, 1, 8'h18, 0, 0, "R4 after combined");
    step(1, 1, 8'h18, 32'hFFFF_FFDF, 0, "R8 status clear");
    step(1, 0, 8'h14, 32'h88, 0, "R8 status closed next");
    step(0, 1, 8'h14, 0, 0, "R10 read other addr");
    step(0, 0, 8'h18, 0, 0, "R10 no read strobe");
    @(negedge clk);
    busWrEn = 0; busRdEn = 0; porRstN = 0; swRst = 1;
    mLock = 4'hF;
    @(negedge clk);
    porRstN = 1; swRst = 0;
    step(0, 1, 8'h18, 0, 0, "R9 por over sw");
    step(1, 0, 8'h10, 32'h99, 0, "R9 ctrl reopened");
    idle();
    check("R7 status store", dStatus, mStatus);
    check("R7 ctrl store", dCtrl, mCtrl);
    check("R7 comp store", dComp, mComp);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule